// File: doc/BRIEF.md
# Interrupt Controller Cascade Unit

This unit lets one interrupt controller act either as the master of a cascaded group or as one of its slaves. With one master and a slave on each of its eight request inputs, the group can serve up to 64 request lines. Only the master raises the processor interrupt line. The cascade bus is three bits wide and is wired pin for pin between the master and every slave. During an interrupt acknowledge, the master uses this bus to name the slave that must answer.

The role comes from a dual-purpose pin. In non-buffered mode the pin is an input: high means master, low means slave. In buffered mode the same pin becomes an output. It enables the external data transceivers while this controller drives the processor data bus, and the role is then taken from a configuration bit. At the start of an acknowledge, the master captures the index of the winning request line. If that line has a slave, the master places the index on the cascade bus and leaves the vector to the slave. Otherwise the master supplies the vector itself. A slave drives the vector only when the cascade bus equals its own programmed ID.

Each controller in a group has its own address and is programmed on its own. The slave map and the slave ID therefore arrive from that controller's configuration registers. The priority resolver and the processor bus timing lie outside this unit.

Top module: `cascade_ctrl`

## Requirements
- R1: With `cfg_buffered`=0, `is_master` equals `sp_en_in` (1 = master, 0 = slave) and `sp_en_oe` is 0.
- R2: With `cfg_buffered`=1, `sp_en_oe` is 1 and `is_master` equals `cfg_buf_master`, whatever the value of `sp_en_in`.
- R3: With `cfg_buffered`=1, `sp_en_out` is 0 (active low) while `data_oe` or `rd_xfer` is 1, and 1 otherwise. With `cfg_buffered`=0, `sp_en_out` is 1.
- R4: A master captures `ack_idx` on the clock edge where `ack_start`=1. From the next cycle, while the acknowledge window is open and bit `ack_idx` of `cfg_slave_map` is 1, it drives `cas_oe`=1 and `cas_out`=captured index, and `data_oe`=0.
- R5: A master whose captured line has a 0 in `cfg_slave_map` drives `data_oe`=1, `cas_oe`=0 and `cas_out`=0 inside the window.
- R6: A slave never sets `cas_oe`. Inside the window it sets `data_oe`=1 exactly when `cas_in` equals `cfg_own_id`.
- R7: The window opens on the edge after `ack_start`=1 and stays open while `ack_active`=1. On the first edge with both `ack_start` and `ack_active` at 0, it closes and leaves `cas_oe`=0 and `data_oe`=0.
- R8: While `rst_n`=0 the window is closed, and `cas_oe`, `data_oe` and `cas_out` are 0.
- R9: Changes on `ack_idx` after the capture edge do not alter `cas_out` within the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_buffered | input | 1 | Buffered mode: dual-purpose pin is an output |
| cfg_buf_master | input | 1 | Role in buffered mode (1 = master) |
| cfg_slave_map | input | 8 | Master: request lines that carry a slave |
| cfg_own_id | input | 3 | Slave: programmed cascade ID |
| sp_en_in | input | 1 | Dual-purpose pin, input value |
| sp_en_out | output | 1 | Dual-purpose pin, buffer enable (active low) |
| sp_en_oe | output | 1 | Dual-purpose pin, output enable |
| ack_start | input | 1 | First acknowledge strobe, captures `ack_idx` |
| ack_active | input | 1 | Acknowledge sequence in progress |
| ack_idx | input | 3 | Winning request line from the priority resolver |
| rd_xfer | input | 1 | Register read to the processor in progress |
| cas_in | input | 3 | Cascade bus, received value |
| cas_out | output | 3 | Cascade bus, driven value |
| cas_oe | output | 1 | Cascade bus output enable |
| data_oe | output | 1 | This device drives the vector onto the data bus |
| is_master | output | 1 | Resolved role (1 = master) |

## Verification
A wrong captured index shows on `cas_out` in the first cycle of the window. A stale or stuck window flag shows one edge after `ack_active` falls: `cas_oe` or `data_oe` stays high, and two devices would then contend for a bus. A wrong role or slave-map decode gives one of two results at the ports, both in the cycle after the capture edge: nobody drives the vector, or the master and a slave both drive it. A broken ID compare makes `data_oe` wrong for one specific `cas_in` value. Sweeping every ID against every bus value exposes it.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } cas_role_e;
endpackage

// File: rtl/cas_role_sel.sv
module cas_role_sel
   import cascade_pkg::*;
#(
   parameter bit EN_ACTIVE_LOW = 1'b1
) (
   input  logic      cfg_buffered,
   input  logic      cfg_buf_master,
   input  logic      sp_en_in,
   input  logic      drive_bus,
   output cas_role_e role,
   output logic      sp_en_out,
   output logic      sp_en_oe
);
   logic en_assert;

   always_comb begin
      if (cfg_buffered) role = cfg_buf_master ? ROLE_MASTER : ROLE_SLAVE;
      else              role = sp_en_in       ? ROLE_MASTER : ROLE_SLAVE;
   end

   assign en_assert = cfg_buffered & drive_bus;
   assign sp_en_oe  = cfg_buffered;

   generate
      if (EN_ACTIVE_LOW) begin : g_low
         assign sp_en_out = ~en_assert;
      end else begin : g_high
         assign sp_en_out = en_assert;
      end
   endgenerate
endmodule

// File: rtl/cas_ack_latch.sv
module cas_ack_latch #(
   parameter int ID_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_start,
   input  logic            ack_active,
   input  logic [ID_W-1:0] ack_idx,
   output logic            win_open,
   output logic [ID_W-1:0] sel_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_open <= 1'b0;
         sel_idx  <= '0;
      end else begin
         win_open <= ack_start | (win_open & ack_active);
         if (ack_start) sel_idx <= ack_idx;
      end
   end
endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv #(
   parameter int ID_W = 3,
   localparam int LINES = 1 << ID_W
) (
   input  logic             active,
   input  logic [ID_W-1:0]  sel_idx,
   input  logic [LINES-1:0] slave_map,
   output logic [ID_W-1:0]  cas_out,
   output logic             cas_oe,
   output logic             vec_oe
);
   logic [LINES-1:0] sel_hot;
   logic             has_slave;

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_dec
         assign sel_hot[i] = (sel_idx == ID_W'(i)) & slave_map[i];
      end
   endgenerate

   assign has_slave = |sel_hot;
   assign cas_oe    = active & has_slave;
   assign vec_oe    = active & ~has_slave;
   assign cas_out   = cas_oe ? sel_idx : '0;
endmodule

// File: rtl/cas_slave_cmp.sv
module cas_slave_cmp #(
   parameter int ID_W = 3
) (
   input  logic            active,
   input  logic [ID_W-1:0] cas_in,
   input  logic [ID_W-1:0] own_id,
   output logic            vec_oe
);
   logic [ID_W-1:0] bit_eq;

   generate
      for (genvar b = 0; b < ID_W; b++) begin : g_cmp
         assign bit_eq[b] = ~(cas_in[b] ^ own_id[b]);
      end
   endgenerate

   assign vec_oe = active & (&bit_eq);
endmodule

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
   import cascade_pkg::*;
#(
   parameter int ID_W = 3,
   parameter bit EN_ACTIVE_LOW = 1'b1,
   localparam int LINES = 1 << ID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_buffered,
   input  logic             cfg_buf_master,
   input  logic [LINES-1:0] cfg_slave_map,
   input  logic [ID_W-1:0]  cfg_own_id,
   input  logic             sp_en_in,
   output logic             sp_en_out,
   output logic             sp_en_oe,
   input  logic             ack_start,
   input  logic             ack_active,
   input  logic [ID_W-1:0]  ack_idx,
   input  logic             rd_xfer,
   input  logic [ID_W-1:0]  cas_in,
   output logic [ID_W-1:0]  cas_out,
   output logic             cas_oe,
   output logic             data_oe,
   output logic             is_master
);
   generate
      if (ID_W < 1 || ID_W > 4) begin : g_bad_width
         $error("cascade_ctrl: ID_W must lie in 1..4");
      end
   endgenerate

   cas_role_e       role;
   logic            win_open;
   logic [ID_W-1:0] sel_idx;
   logic            m_vec_oe;
   logic            s_vec_oe;
   logic            m_cas_oe;
   logic [ID_W-1:0] m_cas_out;

   cas_role_sel #(.EN_ACTIVE_LOW(EN_ACTIVE_LOW)) u_role (
      .cfg_buffered  (cfg_buffered),
      .cfg_buf_master(cfg_buf_master),
      .sp_en_in      (sp_en_in),
      .drive_bus     (data_oe | rd_xfer),
      .role          (role),
      .sp_en_out     (sp_en_out),
      .sp_en_oe      (sp_en_oe)
   );

   cas_ack_latch #(.ID_W(ID_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_start (ack_start),
      .ack_active(ack_active),
      .ack_idx   (ack_idx),
      .win_open  (win_open),
      .sel_idx   (sel_idx)
   );

   cas_master_drv #(.ID_W(ID_W)) u_mdrv (
      .active   (win_open & (role == ROLE_MASTER)),
      .sel_idx  (sel_idx),
      .slave_map(cfg_slave_map),
      .cas_out  (m_cas_out),
      .cas_oe   (m_cas_oe),
      .vec_oe   (m_vec_oe)
   );

   cas_slave_cmp #(.ID_W(ID_W)) u_scmp (
      .active(win_open & (role == ROLE_SLAVE)),
      .cas_in(cas_in),
      .own_id(cfg_own_id),
      .vec_oe(s_vec_oe)
   );

   assign is_master = (role == ROLE_MASTER);
   assign cas_oe    = m_cas_oe;
   assign cas_out   = m_cas_out;
   assign data_oe   = m_vec_oe | s_vec_oe;
endmodule

// File: rtl/cascade_ctrl_chk.sv
module cascade_ctrl_chk #(
   parameter int ID_W = 3,
   parameter bit EN_ACTIVE_LOW = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_buffered,
   input logic            cfg_buf_master,
   input logic            sp_en_in,
   input logic            sp_en_out,
   input logic            sp_en_oe,
   input logic            ack_start,
   input logic            ack_active,
   input logic            rd_xfer,
   input logic [ID_W-1:0] cas_in,
   input logic [ID_W-1:0] cfg_own_id,
   input logic [ID_W-1:0] cas_out,
   input logic            cas_oe,
   input logic            data_oe,
   input logic            is_master
);
   AST_ROLE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_buffered |-> (is_master == sp_en_in) && !sp_en_oe); // R1
   AST_ROLE_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_buffered |-> sp_en_oe && (is_master == cfg_buf_master)); // R2
   AST_BUF_EN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_buffered && (data_oe || rd_xfer)) |-> (sp_en_out == !EN_ACTIVE_LOW)); // R3
   AST_MASTER_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      is_master |-> !(cas_oe && data_oe)); // R4
   AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> !cas_oe); // R6
   AST_SLAVE_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && data_oe) |-> (cas_in == cfg_own_id)); // R6
   AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_active && !ack_start) |=> (!cas_oe && !data_oe)); // R7
   AST_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_oe && $past(cas_oe) && !$past(ack_start)) |-> $stable(cas_out)); // R9
   always_comb begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (!cas_oe && !data_oe && cas_out == '0); // R8
      end
   end
endmodule

bind cascade_ctrl cascade_ctrl_chk #(.ID_W(ID_W), .EN_ACTIVE_LOW(EN_ACTIVE_LOW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_buffered  (cfg_buffered),
   .cfg_buf_master(cfg_buf_master),
   .sp_en_in      (sp_en_in),
   .sp_en_out     (sp_en_out),
   .sp_en_oe      (sp_en_oe),
   .ack_start     (ack_start),
   .ack_active    (ack_active),
   .rd_xfer       (rd_xfer),
   .cas_in        (cas_in),
   .cfg_own_id    (cfg_own_id),
   .cas_out       (cas_out),
   .cas_oe        (cas_oe),
   .data_oe       (data_oe),
   .is_master     (is_master)
);

// File: tb/cascade_ctrl_bench.sv
`timescale 1ns/1ps
module cascade_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_buffered = 1'b0, cfg_buf_master = 1'b0;
   logic [7:0] cfg_slave_map = '0;
   logic [2:0] cfg_own_id = '0;
   logic       sp_en_in = 1'b0;
   logic       sp_en_out, sp_en_oe;
   logic       ack_start = 1'b0, ack_active = 1'b0;
   logic [2:0] ack_idx = '0;
   logic       rd_xfer = 1'b0;
   logic [2:0] cas_in = '0;
   logic [2:0] cas_out;
   logic       cas_oe, data_oe, is_master;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cascade_ctrl u_cascade_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_buffered(cfg_buffered),
      .cfg_buf_master(cfg_buf_master), .cfg_slave_map(cfg_slave_map),
      .cfg_own_id(cfg_own_id), .sp_en_in(sp_en_in), .sp_en_out(sp_en_out),
      .sp_en_oe(sp_en_oe), .ack_start(ack_start), .ack_active(ack_active),
      .ack_idx(ack_idx), .rd_xfer(rd_xfer), .cas_in(cas_in),
      .cas_out(cas_out), .cas_oe(cas_oe), .data_oe(data_oe),
      .is_master(is_master)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_en(input bit buffered, input bit driving);
      return (buffered && driving) ? 0 : 1;
   endfunction

   task automatic master_pass(input bit buffered);
      cfg_buffered = buffered;
      cfg_buf_master = buffered;
      sp_en_in = !buffered;
      for (int m = 0; m < 256; m++) begin
         for (int i = 0; i < 8; i++) begin
            bit has;
            cfg_slave_map = m[7:0];
            has = m[i];
            ack_idx = i[2:0];
            ack_start = 1'b1;
            ack_active = 1'b1;
            tick();
            ack_start = 1'b0;
            #1;
            chk(buffered ? "R2 role" : "R1 role", is_master, 1);
            chk("R4 cas_oe", cas_oe, has);
            chk(has ? "R4 cas_out" : "R5 cas_out", cas_out, has ? i : 0);
            chk(has ? "R4 data_oe" : "R5 data_oe", data_oe, !has);
            chk("R3 sp_en_out", sp_en_out, exp_en(buffered, !has));
            ack_idx = ~i[2:0];
            tick();
            chk("R9 cas_out held", cas_out, has ? i : 0);
            ack_active = 1'b0;
            tick();
            chk("R7 cas_oe closed", cas_oe, 0);
            chk("R7 data_oe closed", data_oe, 0);
         end
      end
   endtask

   task automatic slave_pass(input bit buffered);
      cfg_buffered = buffered;
      cfg_buf_master = 1'b0;
      sp_en_in = buffered;
      for (int id = 0; id < 8; id++) begin
         for (int c = 0; c < 8; c++) begin
            cfg_own_id = id[2:0];
            cas_in = c[2:0];
            ack_idx = 3'(c + 1);
            ack_start = 1'b1;
            ack_active = 1'b1;
            tick();
            ack_start = 1'b0;
            #1;
            chk(buffered ? "R2 slave role" : "R1 slave role", is_master, 0);
            chk("R6 cas_oe", cas_oe, 0);
            chk("R6 data_oe", data_oe, id == c);
            chk("R3 sp_en_out slave", sp_en_out, exp_en(buffered, id == c));
            ack_active = 1'b0;
            tick();
            chk("R7 slave closed", data_oe, 0);
         end
      end
   endtask

   initial begin
      #1;
      chk("R8 cas_oe reset", cas_oe, 0);
      chk("R8 data_oe reset", data_oe, 0);
      chk("R8 cas_out reset", cas_out, 0);
      sp_en_in = 1'b1;
      ack_start = 1'b1;
      ack_active = 1'b1;
      cfg_slave_map = 8'hFF;
      ack_idx = 3'd5;
      tick();
      tick();
      chk("R8 held in reset", cas_oe, 0);
      ack_start = 1'b0;
      ack_active = 1'b0;
      rst_n = 1'b1;
      tick();
      chk("R1 oe off", sp_en_oe, 0);
      chk("R3 unbuffered idle", sp_en_out, 1);
      cfg_buffered = 1'b1;
      #1;
      chk("R2 oe on", sp_en_oe, 1);
      chk("R3 idle high", sp_en_out, 1);
      rd_xfer = 1'b1;
      #1;
      chk("R3 read low", sp_en_out, 0);
      rd_xfer = 1'b0;
      master_pass(1'b0);
      master_pass(1'b1);
      slave_pass(1'b0);
      slave_pass(1'b1);
      cfg_buffered = 1'b0;
      sp_en_in = 1'b1;
      cfg_slave_map = 8'h00;
      ack_start = 1'b1;
      ack_active = 1'b1;
      tick();
      ack_start = 1'b0;
      tick();
      tick();
      chk("R7 window stays open", data_oe, 1);
      ack_active = 1'b0;
      tick();
      chk("R7 window closed", data_oe, 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule